// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block collects up to `NUM_SRC` interrupt lines into a status register, qualifies them with a per-source enable mask and gives the processor one registered interrupt request. It also gives a vector that names the highest-priority pending source. Each source is built as either level-sensitive or rising-edge-sensitive, chosen per bit by the `EDGE_MASK` parameter. Software talks to the block through a plain word-addressed write/read port of eight 32-bit registers.

Enable bits can be changed without a read-modify-write. One alias ORs a mask into the enable register and another clears the bits a mask selects. Status bits are cleared by writing ones to an acknowledge register. A two-bit master control gates the request output and, separately, the capture of new events into status. Software is expected to clear the enables, acknowledge every source and then set both master bits.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every register reads 0, except the vector register (word 6), which reads 0xFFFF_FFFF. `irq_o` is low.
- R2: The enable register is word 2 and is written directly. A write to word 4 ORs the write data into enable. A write to word 5 clears each enable bit whose data bit is 1. Bit i of each mask refers to source i, with bit 0 as the LSB.
- R3: A write to word 3 (acknowledge) clears each status bit (word 0) whose data bit is 1. Writing 0xFFFF_FFFF clears all of them, unless the same cycle also sets a bit.
- R4: A source whose `EDGE_MASK` bit is 1 sets its status bit in the cycle after a 0-to-1 change on its input. The bit then stays set until it is acknowledged. An acknowledge in the same cycle as a new edge leaves the bit set.
- R5: A source whose `EDGE_MASK` bit is 0 sets its status bit on every clock edge at which its input is high. An acknowledge while the input is still high therefore leaves the bit set.
- R6: Word 1 (pending) reads as status AND enable. Writes to words 0, 1 and 6 change nothing. Words 3, 4 and 5 read as 0.
- R7: Word 6 (vector) reads as the index of the lowest-numbered pending source, zero-extended. When no source is pending it reads 0xFFFF_FFFF.
- R8: Master control is word 7, bits [1:0]. While bit 1 is 0, no status bit can be set. Edge detection keeps tracking the inputs during this time, so an input that is already high does not count as an edge when capture is turned back on.
- R9: `irq_o` is a register. It is 1 in the cycle after one in which some pending bit was set and master bit 0 was 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Interrupt source lines, synchronous to clk |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The bench raises an edge source in the same cycle as its acknowledge. A design that gives priority to the clear would lose that event. It also acknowledges a level source while the line is still high, which catches a status bit that stays cleared. A source line is held high across a period with capture off, so that a design that stops tracking the edge history would set a false event when capture resumes. The timing of `irq_o` is checked against enable changes and master changes, to show the output lags by exactly one register.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int WORD_W = 32;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RG_STATUS = 3'd0,
      RG_PEND   = 3'd1,
      RG_ENABLE = 3'd2,
      RG_ACK    = 3'd3,
      RG_SETEN  = 3'd4,
      RG_CLREN  = 3'd5,
      RG_VECTOR = 3'd6,
      RG_MASTER = 3'd7
   } reg_idx_e;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
   parameter int              NUM_SRC   = 8,
   parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic               latch_en,
   input  logic [NUM_SRC-1:0] ack,
   output logic [NUM_SRC-1:0] status
);
   logic [NUM_SRC-1:0] set_v;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic hit;
      logic stat_q;
      if (EDGE_MASK[i]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src[i];
         end
         assign hit = src[i] & ~prev_q;
      end else begin : g_level
         assign hit = src[i];
      end
      assign set_v[i] = hit & latch_en;
      always_ff @(posedge clk) begin
         if (!rst_n) stat_q <= 1'b0;
         else        stat_q <= set_v[i] | (stat_q & ~ack[i]);
      end
      assign status[i] = stat_q;
   end

   // R3
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(ack) & ~$past(set_v) & status) == '0));
   // R4
   status_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(status) & ~$past(ack) & ~status) == '0));
   // R8
   latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_en |=> ((status & ~$past(status)) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int NUM_SRC = 8,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
   assign any = |req;

   logic [NUM_SRC-1:0] below;
   assign below = NUM_SRC'((64'd1 << idx) - 64'd1);

   // R7
   winner_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[idx]);
   // R7
   winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((req & below) == '0));
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 8,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [WORD_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] status,
   input  logic [NUM_SRC-1:0] pend,
   input  logic               vec_any,
   input  logic [IDX_W-1:0]   vec_idx,
   output logic [NUM_SRC-1:0] enable,
   output logic [1:0]         master,
   output logic [NUM_SRC-1:0] ack,
   output logic [WORD_W-1:0]  rdata
);
   logic [NUM_SRC-1:0] en_q;
   logic [1:0]         me_q;
   logic [NUM_SRC-1:0] wmask;
   logic               unused_wbits;

   assign wmask        = wdata[NUM_SRC-1:0];
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
         me_q <= 2'b00;
      end else if (wr) begin
         case (addr)
            RG_ENABLE: en_q <= wmask;
            RG_SETEN:  en_q <= en_q | wmask;
            RG_CLREN:  en_q <= en_q & ~wmask;
            RG_MASTER: me_q <= wdata[1:0];
            default:   ;
         endcase
      end
   end

   assign ack    = (wr && addr == RG_ACK) ? wmask : '0;
   assign enable = en_q;
   assign master = me_q;

   always_comb begin
      rdata = '0;
      case (addr)
         RG_STATUS: rdata[NUM_SRC-1:0] = status;
         RG_PEND:   rdata[NUM_SRC-1:0] = pend;
         RG_ENABLE: rdata[NUM_SRC-1:0] = en_q;
         RG_VECTOR: rdata = vec_any ? WORD_W'(vec_idx) : '1;
         RG_MASTER: rdata[1:0] = me_q;
         default:   rdata = '0;
      endcase
   end

   // R2
   set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == RG_SETEN) |=> ((enable & $past(wmask)) == $past(wmask)));
   // R2
   clr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == RG_CLREN) |=> ((enable & $past(wmask)) == '0));
   // R2
   set_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == RG_SETEN) |=> (($past(enable) & ~enable) == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqc_pkg::*;
#(
   parameter int                 NUM_SRC   = 8,
   parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_src,
   input  logic               bus_wr,
   input  logic [2:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_o
);
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 1 || NUM_SRC > WORD_W) begin : g_bad_num
      $error("NUM_SRC must lie in 1..32");
   end

   logic [NUM_SRC-1:0] status, enable, pend, ack;
   logic [1:0]         master;
   logic               vec_any;
   logic [IDX_W-1:0]   vec_idx;
   logic               irq_q;

   irqc_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
      .clk(clk), .rst_n(rst_n), .src(irq_src), .latch_en(master[1]),
      .ack(ack), .status(status));

   assign pend = status & enable;

   irqc_prio #(.NUM_SRC(NUM_SRC)) u_prio (
      .clk(clk), .rst_n(rst_n), .req(pend), .any(vec_any), .idx(vec_idx));

   irqc_regfile #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .status(status), .pend(pend), .vec_any(vec_any),
      .vec_idx(vec_idx), .enable(enable), .master(master), .ack(ack),
      .rdata(bus_rdata));

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= vec_any & master[0];
   end
   assign irq_o = irq_q;

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master[0] |=> !irq_o);
   // R9
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(pend != '0));
   // R9
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (master[0] && pend != '0) |=> irq_o);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
   localparam int         N    = 8;
   localparam logic [7:0] EDGE = 8'hF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src = '0;
   logic        wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   irq_vector_ctrl #(.NUM_SRC(N), .EDGE_MASK(EDGE)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

   // behavioural reference model
   logic [7:0] m_stat, m_en, m_prev;
   logic [1:0] m_me;
   logic       m_irq;

   always @(posedge clk) begin
      logic [7:0] ackm, setm, nen;
      logic [1:0] nme;
      if (!rst_n) begin
         m_stat = 0; m_en = 0; m_prev = 0; m_me = 0; m_irq = 0;
      end else begin
         ackm = 0; nen = m_en; nme = m_me;
         if (wr) begin
            if (addr == 3) ackm = wdata[7:0];
            if (addr == 2) nen = wdata[7:0];
            if (addr == 4) nen = m_en | wdata[7:0];
            if (addr == 5) nen = m_en & ~wdata[7:0];
            if (addr == 7) nme = wdata[1:0];
         end
         setm = 0;
         for (int i = 0; i < 8; i++) begin
            if (m_me[1]) begin
               if (EDGE[i]) setm[i] = src[i] && !m_prev[i];
               else         setm[i] = src[i];
            end
         end
         m_irq  = ((m_stat & m_en) != 0) && m_me[0];
         m_stat = (m_stat & ~ackm) | setm;
         m_prev = src;
         m_en   = nen;
         m_me   = nme;
      end
   end

   function automatic logic [31:0] mread(input logic [2:0] a);
      logic [7:0] p;
      p = m_stat & m_en;
      case (a)
         3'd0: return {24'd0, m_stat};
         3'd1: return {24'd0, p};
         3'd2: return {24'd0, m_en};
         3'd6: begin
            for (int i = 0; i < 8; i++) if (p[i]) return 32'(i);
            return 32'hFFFF_FFFF;
         end
         3'd7: return {30'd0, m_me};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp,
                        input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({31'd0, irq}, {31'd0, m_irq}, "R9 model irq");
         check(rdata, mread(addr), "R6 model read");
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wreg(input logic [2:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      tick(1);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rreg(input logic [2:0] a, input logic [31:0] exp,
                       input string tag);
      addr = a;
      #1;
      check(rdata, exp, tag);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      rreg(0, 0, "R1 status"); rreg(1, 0, "R1 pending");
      rreg(2, 0, "R1 enable"); rreg(6, 32'hFFFF_FFFF, "R1 vector");
      rreg(7, 0, "R1 master"); check({31'd0, irq}, 0, "R1 irq");
      // R8: capture off, level line high
      src[2] = 1'b1;
      tick(3);
      rreg(0, 0, "R8 no capture while off");
      // init sequence
      wreg(2, 0); wreg(3, 32'hFFFF_FFFF); wreg(7, 3);
      tick(1);
      rreg(0, 32'h04, "R5 level capture");
      rreg(1, 0, "R6 pending masked");
      rreg(6, 32'hFFFF_FFFF, "R7 none pending");
      // R2 set-enable
      wreg(4, 32'h24);
      rreg(2, 32'h24, "R2 set-enable");
      check({31'd0, irq}, 0, "R9 irq one cycle late");
      tick(1);
      check({31'd0, irq}, 1, "R9 irq asserted");
      rreg(6, 2, "R7 vector 2");
      // R4 edge source 5
      src[5] = 1'b1; tick(1);
      rreg(0, 32'h24, "R4 edge capture");
      src[5] = 1'b0; tick(2);
      rreg(0, 32'h24, "R4 edge held");
      src[2] = 1'b0; tick(1);
      wreg(3, 32'h04);
      rreg(0, 32'h20, "R3 ack clears bit2");
      rreg(6, 5, "R7 vector 5");
      // R5 ack while level high
      src[2] = 1'b1; tick(1);
      wreg(3, 32'h04);
      rreg(0, 32'h24, "R5 ack while high re-sets");
      src[2] = 1'b0; tick(1);
      wreg(3, 32'h04);
      rreg(0, 32'h20, "R5 cleared after drop");
      // R4 edge in same cycle as ack
      src[4] = 1'b1;
      wreg(3, 32'h10);
      rreg(0, 32'h30, "R4 edge wins over ack");
      wreg(3, 32'h10);
      rreg(0, 32'h20, "R4 ack with no new edge");
      // R2 clear-enable
      wreg(5, 32'h20);
      rreg(2, 32'h04, "R2 clear-enable");
      rreg(1, 0, "R6 pending zero");
      rreg(6, 32'hFFFF_FFFF, "R7 all ones");
      tick(1);
      check({31'd0, irq}, 0, "R9 irq drops");
      // R6 writes to read-only words
      wreg(0, 32'hFF); wreg(1, 32'hFF); wreg(6, 32'hFF);
      rreg(0, 32'h20, "R6 status write ignored");
      rreg(2, 32'h04, "R6 enable untouched");
      rreg(3, 0, "R6 ack reads 0");
      rreg(4, 0, "R6 seten reads 0");
      rreg(5, 0, "R6 clren reads 0");
      // R8 capture off while lines rise
      wreg(7, 1);
      src[3] = 1'b1; src[6] = 1'b1;
      tick(2);
      rreg(0, 32'h20, "R8 status frozen");
      wreg(7, 3);
      tick(1);
      rreg(0, 32'h28, "R8 stale edge ignored");
      // R9 master bit 0 gates irq
      wreg(2, 32'h08);
      wreg(7, 2);
      tick(2);
      check({31'd0, irq}, 0, "R9 gated by master bit0");
      rreg(1, 32'h08, "R6 pending 0x08");
      rreg(6, 3, "R7 vector 3");
      // R3 ack all
      wreg(3, 32'hFFFF_FFFF);
      rreg(0, 32'h08, "R3 ack all with level high");
      src = '0; tick(1);
      wreg(3, 32'hFFFF_FFFF);
      rreg(0, 0, "R3 ack all");
      tick(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule